// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block is a full-duplex serial port that moves eight-bit characters in step with a serial clock. The clock comes from one of two places. In internal mode the block toggles its own serial clock on each baud tick from a shared rate generator and drives that clock out. In external mode it follows a serial clock from another device. Each character goes out and comes in least significant bit first. Data changes on the falling clock edge and is sampled on the rising edge.

Both directions have a holding register in front of a shift register. Software, or a DMA engine reacting to the status outputs, can load the next transmit character while the current one is still shifting, and can read a received character while the next one arrives. The status outputs are transmit-buffer-empty, transmit-finished, receive-full and overrun. Overrun is the only receive error. When it occurs the incoming character is discarded, and reception stays frozen until the error is cleared.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, tx_empty=1, tx_end=1, rx_full=0, overrun=0, sck_out=1 and txd=1.
- R2: A character is 8 bits sent least significant bit first. txd takes the next bit after each falling serial clock edge, and rxd is sampled on each rising edge.
- R3: When ext_clk_sel=0, sck_oe=1. sck_out toggles once per baud_tick only while a character is being shifted: 8 falling edges per character. It sits at 1 whenever tx_end=1.
- R4: When ext_clk_sel=1, sck_oe=0. Both directions shift on the edges of sck_in after a two-flop synchroniser. The bench keeps sck_in at no more than a quarter of clk.
- R5: A character written while another is shifting is sent straight after it, with no idle serial clock in between. A burst of N characters finishes within 64·N+8 clk cycles when baud_tick arrives every 4 cycles.
- R6: A tx_wr pulse while tx_empty=1 is accepted and clears tx_empty on the next cycle. A tx_wr pulse while tx_empty=0 is ignored, and its data is never sent. tx_end=1 only when the buffer and the shifter are both empty.
- R7: After 8 rising edges with rx_en=1, the assembled character appears on rx_data and rx_full rises. rx_data holds until rx_rd, and rx_rd clears rx_full.
- R8: If a character completes while rx_full=1 and rx_rd is not pulsed, the character is dropped and overrun is set while rx_data keeps the older value. Further rising edges are ignored until an err_clr pulse clears overrun.
- R9: Transmit and receive shift at the same time on the same serial clock. A received character and a sent character are exchanged during the same 8 clock periods.
- R10: While rx_en=0, rising edges do not shift the receiver and rx_full does not rise. Driving rx_en low also restarts the receiver's bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk_sel | input | 1 | 0: internal serial clock, 1: external sck_in |
| baud_tick | input | 1 | One-cycle pulse per half serial clock period (internal mode) |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock, idles high |
| sck_oe | output | 1 | Output enable for sck_out |
| txd | output | 1 | Serial data out, idles high |
| rxd | input | 1 | Serial data in |
| tx_wr | input | 1 | Write pulse for the transmit buffer |
| tx_data | input | 8 | Character to transmit |
| tx_empty | output | 1 | Transmit buffer can take a character |
| tx_end | output | 1 | Transmit buffer and shifter both idle |
| rx_en | input | 1 | Receiver enable |
| rx_rd | input | 1 | Read pulse, releases the receive buffer |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | Receive buffer holds an unread character |
| overrun | output | 1 | A character was lost because the buffer was full |
| err_clr | input | 1 | Pulse that clears overrun |

## Verification
The checker assumes that tx_wr, rx_rd and err_clr are single-cycle pulses. It also assumes that rx_en only changes while the receiver is between characters, or when the bench wants the partial character thrown away. The external serial clock is assumed to stay at each level for at least four system clocks, and rxd is assumed stable from one falling edge until well after the following synchronised rising edge. The bench holds each sck_in level for four clk cycles, changes rxd only together with a falling sck_in, and generates baud_tick every fourth cycle.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic {
        CLK_INT = 1'b0,
        CLK_EXT = 1'b1
    } clk_src_e;

    // single-cycle strobes marking serial clock transitions
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_edge_t;

    function automatic int cnt_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
    import ssp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  clk_src_e  src,
    input  logic      baud_tick,
    input  logic      run,
    input  logic      sck_in,
    output sck_edge_t edges,
    output logic      sck_out,
    output logic      sck_oe
);

    logic [SYNC_STAGES:0] sync_q;
    logic                 sck_int;
    logic                 run_int;
    sck_edge_t            ext_e, int_e;

    assign run_int = run && (src == CLK_INT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= '1;
            sck_int <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], sck_in};
            if (!run_int)
                sck_int <= 1'b1;
            else if (baud_tick)
                sck_int <= ~sck_int;
        end
    end

    always_comb begin
        ext_e.rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
        ext_e.fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];
        int_e.rise = run_int & baud_tick & ~sck_int;
        int_e.fall = run_int & baud_tick & sck_int;
        edges      = (src == CLK_EXT) ? ext_e : int_e;
    end

    assign sck_out = sck_int;
    assign sck_oe  = (src == CLK_INT);

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int DW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [DW-1:0] din,
    input  sck_edge_t     edges,
    output logic          txd,
    output logic          empty,
    output logic          done,
    output logic          active
);

    localparam int BW = cnt_w(DW);
    localparam logic [BW-1:0] LAST = BW'(DW - 1);

    logic [DW-1:0] hold_q, shf_q;
    logic          hold_full;
    logic [BW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            shf_q     <= '0;
            cnt_q     <= '0;
            active    <= 1'b0;
            txd       <= 1'b1;
        end else begin
            if (wr && !hold_full) begin
                hold_q    <= din;
                hold_full <= 1'b1;
            end
            if (!active) begin
                if (hold_full) begin
                    shf_q     <= hold_q;
                    hold_full <= 1'b0;
                    active    <= 1'b1;
                    cnt_q     <= '0;
                end
            end else begin
                if (edges.fall) begin
                    txd   <= shf_q[0];
                    shf_q <= shf_q >> 1;
                end
                if (edges.rise) begin
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        if (hold_full) begin
                            shf_q     <= hold_q;
                            hold_full <= 1'b0;
                        end else begin
                            active <= 1'b0;
                            txd    <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign empty = !hold_full;
    assign done  = !hold_full && !active;

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int DW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          rxd,
    input  sck_edge_t     edges,
    input  logic          rd,
    input  logic          clr,
    output logic [DW-1:0] dout,
    output logic          full,
    output logic          ovr
);

    localparam int BW = cnt_w(DW);
    localparam logic [BW-1:0] LAST = BW'(DW - 1);

    logic [DW-1:0] shf_q, shf_nxt;
    logic [BW-1:0] cnt_q;

    assign shf_nxt = {rxd, shf_q[DW-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            shf_q <= '0;
            cnt_q <= '0;
            dout  <= '0;
            full  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (rd)  full <= 1'b0;
            if (clr) ovr  <= 1'b0;
            if (!en) begin
                cnt_q <= '0;
            end else if (edges.rise && !ovr) begin
                shf_q <= shf_nxt;
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    if (full && !rd) begin
                        ovr <= 1'b1;
                    end else begin
                        dout <= shf_nxt;
                        full <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int DW          = CHAR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ext_clk_sel,
    input  logic          baud_tick,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe,
    output logic          txd,
    input  logic          rxd,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    output logic          tx_empty,
    output logic          tx_end,
    input  logic          rx_en,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          overrun,
    input  logic          err_clr
);

    sck_edge_t edges;
    logic      tx_busy;
    clk_src_e  src;

    assign src = clk_src_e'(ext_clk_sel);

    ssp_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk(clk), .rst(rst), .src(src), .baud_tick(baud_tick),
        .run(tx_busy), .sck_in(sck_in), .edges(edges),
        .sck_out(sck_out), .sck_oe(sck_oe)
    );

    ssp_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst(rst), .wr(tx_wr), .din(tx_data), .edges(edges),
        .txd(txd), .empty(tx_empty), .done(tx_end), .active(tx_busy)
    );

    ssp_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .rxd(rxd), .edges(edges),
        .rd(rx_rd), .clr(err_clr), .dout(rx_data), .full(rx_full),
        .ovr(overrun)
    );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_clk_sel,
    input logic          sck_out,
    input logic          tx_wr,
    input logic          tx_empty,
    input logic          tx_end,
    input logic          rx_en,
    input logic          rx_rd,
    input logic [DW-1:0] rx_data,
    input logic          rx_full,
    input logic          overrun,
    input logic          err_clr
);

    AST_IDLE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!ext_clk_sel && tx_end) |-> sck_out);                         // R3
    AST_WR_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_empty) |=> !tx_empty);                            // R6
    AST_END_MEANS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        tx_end |-> tx_empty);                                          // R6
    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));        // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overrun && !err_clr) |=> overrun);                            // R8
    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> rx_full);                                   // R8
    AST_RX_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !rx_full) |=> !rx_full);                            // R10

endmodule

bind sync_serial_port ssp_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst(rst), .ext_clk_sel(ext_clk_sel), .sck_out(sck_out),
    .tx_wr(tx_wr), .tx_empty(tx_empty), .tx_end(tx_end), .rx_en(rx_en),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
    .overrun(overrun), .err_clr(err_clr)
);

// File: tb/sim_sync_serial_port.sv
`timescale 1ns/1ps
module sim_sync_serial_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk_sel = 1'b0;
    logic       baud_tick;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, txd, rxd;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_empty, tx_end;
    logic       rx_en = 1'b1;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, overrun;
    logic       err_clr = 1'b0;

    logic       loop = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       mon_en = 1'b0;
    logic [1:0] tick_div = '0;
    int         n_chk = 0, n_fail = 0, n_rx = 0, n_fall = 0;
    logic       sck_prev = 1'b1;
    bit         finished = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    assign rxd       = loop ? txd : rxd_drv;
    assign baud_tick = (tick_div == 2'd3);

    always @(posedge clk) tick_div <= tick_div + 2'd1;

    always @(negedge clk) begin
        if (!ext_clk_sel && sck_prev && !sck_out) n_fall++;
        sck_prev = sck_out;
    end

    sync_serial_port u0 (
        .clk(clk), .rst(rst), .ext_clk_sel(ext_clk_sel), .baud_tick(baud_tick),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .txd(txd),
        .rxd(rxd), .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty),
        .tx_end(tx_end), .rx_en(rx_en), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_full(rx_full), .overrun(overrun), .err_clr(err_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // driver: write one character, optionally record it as expected on rxd side
    task automatic tx_write(input logic [7:0] b, input bit expect_rx);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        tx_data = b;
        tx_wr   = 1'b1;
        if (expect_rx) exp_q.push_back(b);
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_end) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    // monitor: pops expected characters as the receiver delivers them
    initial begin
        forever begin
            @(negedge clk);
            if (mon_en && rx_full && !rx_rd) begin
                n_rx++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected char", rx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R2/R7 rx char", rx_data, e);
                end
                rx_rd = 1'b1;
            end else if (mon_en) begin
                rx_rd = 1'b0;
            end
        end
    end

    // external clock exchange of one character
    task automatic ext_xfer(input logic [7:0] rb, output logic [7:0] tb);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            sck_in  = 1'b0;
            rxd_drv = rb[i];
            repeat (4) @(negedge clk);
            tb[i]  = txd;
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t0, t1;
        logic [7:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
        chk(tx_end == 1, "R1 tx_end", tx_end, 1);
        chk(rx_full == 0, "R1 rx_full", rx_full, 0);
        chk(overrun == 0, "R1 overrun", overrun, 0);
        chk(sck_out == 1 && txd == 1, "R1 sck/txd idle", {sck_out, txd}, 3);
        chk(sck_oe == 1, "R3 sck_oe internal", sck_oe, 1);

        // burst in internal loopback: R2 R3 R5 R6 R7 R9
        mon_en = 1'b1;
        n_fall = 0;
        t0 = $time / 8;
        tx_write(8'hA5, 1);
        tx_write(8'h3C, 1);
        chk(tx_end == 0, "R5 second write while busy", tx_end, 0);
        // buffer now full: this write must be ignored (R6)
        tx_data = 8'h77; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        chk(tx_empty == 0, "R6 full write ignored", tx_empty, 0);
        tx_write(8'hFF, 1);
        tx_write(8'h00, 1);
        tx_write(8'h81, 1);
        @(negedge clk);
        while (!tx_end) @(negedge clk);
        t1 = $time / 8;
        chk((t1 - t0) <= 5 * 64 + 8, "R5 no gap in burst", t1 - t0, 5 * 64 + 8);
        repeat (4) @(negedge clk);
        chk(n_fall == 40, "R3 falls per char", n_fall, 40);
        chk(sck_out == 1, "R3 idle high", sck_out, 1);
        chk(exp_q.size() == 0 && n_rx == 5, "R7 all chars received", n_rx, 5);

        // overrun: R8
        mon_en = 1'b0;
        rx_rd  = 1'b0;
        tx_write(8'h12, 0); wait_idle();
        chk(rx_full == 1 && rx_data == 8'h12, "R7 first char held", rx_data, 8'h12);
        tx_write(8'h34, 0); wait_idle();
        chk(overrun == 1, "R8 overrun set", overrun, 1);
        chk(rx_data == 8'h12, "R8 old data kept", rx_data, 8'h12);
        pulse_rd();
        chk(rx_full == 0, "R7 rx_rd clears", rx_full, 0);
        tx_write(8'h56, 0); wait_idle();
        chk(rx_full == 0 && overrun == 1, "R8 blocked until clear", {overrun, rx_full}, 2);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(overrun == 0, "R8 err_clr", overrun, 0);
        mon_en = 1'b1;
        tx_write(8'h9B, 1); wait_idle();
        chk(exp_q.size() == 0, "R8 reception resumes", exp_q.size(), 0);

        // R10 receiver disabled
        rx_en = 1'b0;
        tx_write(8'hC3, 0); wait_idle();
        chk(rx_full == 0, "R10 rx_en low ignored", rx_full, 0);
        rx_en = 1'b1;

        // external clock, full duplex: R4 R9
        loop = 1'b0;
        ext_clk_sel = 1'b1;
        repeat (4) @(negedge clk);
        chk(sck_oe == 0, "R4 sck_oe external", sck_oe, 0);
        tx_write(8'h5A, 0);
        tx_write(8'hE7, 0);
        repeat (4) @(negedge clk);
        exp_q.push_back(8'h96);
        ext_xfer(8'h96, got);
        chk(got == 8'h5A, "R4/R9 ext tx char 1", got, 8'h5A);
        exp_q.push_back(8'h0F);
        ext_xfer(8'h0F, got);
        chk(got == 8'hE7, "R5/R9 ext tx char 2", got, 8'hE7);
        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R4/R9 ext rx chars", exp_q.size(), 0);
        chk(tx_end == 1 && txd == 1, "R6 ext tx_end", {tx_end, txd}, 3);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule